// File: doc/BRIEF.md
# Serial converter slave interface

This block is the digital, device-side half of a serial sampling converter. The analog successive-approximation core is replaced by a parallel `sample` input. All logic runs on the system clock `clk`. The serial pins `cs_n`, `dclk` and `din` are expected to be synchronous to `clk`, and `dclk` is oversampled to find its rising and falling edges. While chip select is low, the block looks for a start bit on `din` and assembles an eight-bit command behind it. From that command it drives a channel select, a single-ended/differential flag, the acquire and hold phase strobes and a power mode. It then produces a busy indication and returns the captured sample MSB first on `dout`, followed by zeros. High impedance is modelled by the separate enables `dout_en` and `busy_en`.

The command bits arrive MSB first. Bit 7 is the start bit (1). Bits 6:4 are the channel number. Bit 3 is ignored. Bit 2 selects single-ended (1) or differential (0). Bits 1:0 are the power mode. Power mode 10 selects the internal clock: a timer of `CONV_CYCLES` system clocks performs the conversion, and the result waits in the output register until the host clocks it out. Every other power mode uses the external clock, where each `dclk` falling edge steps the conversion. Power mode 00 raises `low_power` between conversions. Mode 11 keeps the device powered. Mode 01 is reserved and behaves as mode 11.

The state machine has four states. `ST_HUNT` waits for a start bit. `ST_CMD` collects the seven command bits that follow. `ST_EXT_SAMPLE` waits for the falling edge that captures the sample in external-clock mode. `ST_INT_CONV` runs the internal conversion timer. The transitions are:
- HUNT→CMD on a rising edge with `din`=1.
- CMD→HUNT when chip select rises.
- CMD→EXT_SAMPLE on the eighth rising edge for any mode other than 10.
- CMD→INT_CONV on the eighth rising edge for mode 10.
- EXT_SAMPLE→HUNT on the next falling edge, or when chip select rises.
- INT_CONV→HUNT when the timer ends.

The result shifter runs independently of the state machine, so a new command can be received while the previous result is still leaving.

Top module: `adc_serial_slave`

## Requirements
- R1: While `cs_n` is low, `din` is sampled on each `dclk` rising edge. In the idle state, zeros are ignored. The first 1 is taken as command bit 7 (start), and the next seven rising edges supply bits 6 to 0.
- R2: On the sixth command rising edge, `chan_sel` takes bits 6:4, `single_ended` takes bit 2 and `acquire` goes high. On the eighth rising edge, `acquire` falls, `hold` rises and the power mode takes bits 1:0.
- R3: In external-clock modes (power mode other than 10), `busy` is high from the first `dclk` falling edge after the eighth command rising edge until the next falling edge. The `sample` value is captured on that first falling edge.
- R4: Each of the following 16 falling edges presents one result bit on `dout`, MSB first. After the LSB, `dout` presents 0 on every falling edge. `hold` falls once the LSB has been presented.
- R5: While `cs_n` is high, `dout_en` is low and `dclk` edges are ignored. `busy_en` is also low, except during an internal conversion.
- R6: A start bit is accepted while the previous result is still being shifted out, so conversions can run back to back in 24 `dclk` periods.
- R7: In power mode 10, `busy` and `hold` are high from the eighth command rising edge for `CONV_CYCLES` clocks. `sample` is then captured, and `busy` and `hold` fall.
- R8: After an internal conversion, the first `dclk` falling edge with `cs_n` low presents the MSB, whether `cs_n` stayed low or was high when `busy` fell. `busy_en` stays high through an internal conversion even with `cs_n` high.
- R9: `low_power` is high when the last power mode was 00 and neither `acquire` nor `hold` is high. Modes 01 and 11 keep `low_power` low and use the external clock.
- R10: Raising `cs_n` before the eighth command bit abandons the command and returns to start-bit hunting, leaving `chan_sel` unchanged if the sixth bit was not reached.
- R11: After reset, `dout`, `busy`, `acquire`, `hold`, `chan_sel` and `single_ended` are 0, the power mode is 00 and `low_power` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| dclk | input | 1 | Serial data clock, oversampled by `clk` |
| din | input | 1 | Serial command input |
| sample | input | DATA_W | Parallel conversion value standing in for the analog core |
| dout | output | 1 | Serial result output |
| dout_en | output | 1 | Drive enable for `dout` (low means high impedance) |
| busy | output | 1 | Conversion busy indication |
| busy_en | output | 1 | Drive enable for `busy` |
| chan_sel | output | 3 | Input multiplexer channel number |
| single_ended | output | 1 | 1 selects single-ended, 0 selects differential |
| acquire | output | 1 | Sampling phase strobe |
| hold | output | 1 | Hold/convert phase strobe |
| low_power | output | 1 | Power-down flag between conversions |

## Verification
A state machine that stays in or leaves the hunt state at the wrong moment shifts every later command by whole bits. This corrupts `chan_sel` at the sixth rising edge and misplaces the `busy` pulse within one `dclk` period of the fault. A wrong shifter count shows up as a wrong or missing result bit on the first affected falling edge, or as ones where the zero fill should be. In back-to-back framing, a hold strobe that never clears shows up at once as `low_power` staying low. A broken internal timer shows up as `busy` falling too early or too late, which is seen within `CONV_CYCLES` clocks.

// File: rtl/adc_slv_pkg.sv
package adc_slv_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_HUNT       = 2'd0,
        ST_CMD        = 2'd1,
        ST_EXT_SAMPLE = 2'd2,
        ST_INT_CONV   = 2'd3
    } slv_state_e;

    // Power-mode codes carried in command bits 1:0
    localparam logic [1:0] PD_AUTO   = 2'b00;
    localparam logic [1:0] PD_INTCLK = 2'b10;

    // Command framing
    localparam int CMD_BITS      = 8;
    localparam int MUX_READY_BIT = 6;   // rising edge on which the mux fields are complete

endpackage

// File: rtl/adc_slv_edge.sv
module adc_slv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk,
    input  logic cs_n,
    output logic rise,
    output logic fall
);
    logic dclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dclk_q <= 1'b0;
        end else begin
            dclk_q <= dclk;
        end
    end

    // Edges only count while the device is selected
    assign rise = !cs_n && dclk && !dclk_q;
    assign fall = !cs_n && !dclk && dclk_q;

endmodule

// File: rtl/adc_slv_timer.sv
module adc_slv_timer #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int TW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

    logic          running;
    logic [TW-1:0] cnt;

    assign done = running && (cnt == TW'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (done) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (running) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (int'(cnt) < CYCLES)) else $error("timer overran"); // R7

endmodule

// File: rtl/adc_slv_shifter.sv
module adc_slv_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] data,
    output logic         dout,
    output logic         empty
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sr;
    logic [CW-1:0] cnt;

    assign empty = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            cnt  <= '0;
            dout <= 1'b0;
        end else if (load) begin
            sr   <= data;
            cnt  <= CW'(W);
            dout <= 1'b0;
        end else if (shift) begin
            if (cnt != '0) begin
                dout <= sr[W-1];
                sr   <= {sr[W-2:0], 1'b0};
                cnt  <= cnt - 1'b1;
            end else begin
                dout <= 1'b0;
            end
        end
    end

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && empty) |=> !dout) else $error("zero fill broken"); // R4

endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
    import adc_slv_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              dclk,
    input  logic              din,
    input  logic [DATA_W-1:0] sample,
    output logic              dout,
    output logic              dout_en,
    output logic              busy,
    output logic              busy_en,
    output logic [2:0]        chan_sel,
    output logic              single_ended,
    output logic              acquire,
    output logic              hold,
    output logic              low_power
);
    localparam int BCW = $clog2(CMD_BITS);
    localparam logic [BCW-1:0] MUX_AT  = BCW'(MUX_READY_BIT - 1);
    localparam logic [BCW-1:0] LAST_AT = BCW'(CMD_BITS - 1);

    slv_state_e     state, state_nx;
    logic           rise, fall;
    logic [BCW-1:0] bitcnt;
    logic [3:0]     cmd_sr;
    logic [1:0]     pd_q;
    logic           mux_step, last_step, int_req;
    logic           tmr_done;
    logic           sh_load, sh_shift, sh_empty;

    adc_slv_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .dclk  (dclk),
        .cs_n  (cs_n),
        .rise  (rise),
        .fall  (fall)
    );

    adc_slv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (last_step && int_req),
        .done  (tmr_done)
    );

    adc_slv_shifter #(.W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .shift (sh_shift),
        .data  (sample),
        .dout  (dout),
        .empty (sh_empty)
    );

    // Decode strobes
    assign mux_step  = (state == ST_CMD) && rise && (bitcnt == MUX_AT);
    assign last_step = (state == ST_CMD) && rise && (bitcnt == LAST_AT);
    assign int_req   = ({cmd_sr[0], din} == PD_INTCLK);
    assign sh_load   = ((state == ST_EXT_SAMPLE) && fall) || tmr_done;
    assign sh_shift  = fall && !sh_load;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT: begin
                if (rise && din) state_nx = ST_CMD;
            end
            ST_CMD: begin
                if (cs_n)           state_nx = ST_HUNT;
                else if (last_step) state_nx = int_req ? ST_INT_CONV : ST_EXT_SAMPLE;
            end
            ST_EXT_SAMPLE: begin
                if (cs_n || fall) state_nx = ST_HUNT;
            end
            ST_INT_CONV: begin
                if (tmr_done) state_nx = ST_HUNT;
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    // Command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            cmd_sr <= '0;
        end else if ((state == ST_HUNT) && rise && din) begin
            bitcnt <= BCW'(1);
            cmd_sr <= '0;
        end else if ((state == ST_CMD) && rise) begin
            bitcnt <= bitcnt + 1'b1;
            cmd_sr <= {cmd_sr[2:0], din};
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            acquire      <= 1'b0;
            hold         <= 1'b0;
            chan_sel     <= '0;
            single_ended <= 1'b0;
            pd_q         <= PD_AUTO;
        end else begin
            // external-clock busy lasts one dclk period
            if (busy && (state != ST_INT_CONV) && (fall || cs_n)) busy <= 1'b0;
            // external hold ends once the LSB has left
            if (hold && ((state == ST_HUNT) || (state == ST_CMD)) && sh_empty) hold <= 1'b0;
            if ((state == ST_CMD) && cs_n) acquire <= 1'b0;
            if (mux_step) begin
                chan_sel     <= cmd_sr[3:1];
                single_ended <= din;
                acquire      <= 1'b1;
            end
            if (last_step) begin
                acquire <= 1'b0;
                hold    <= 1'b1;
                pd_q    <= {cmd_sr[0], din};
                if (int_req) busy <= 1'b1;
            end
            if (state == ST_EXT_SAMPLE) begin
                if (cs_n)      hold <= 1'b0;
                else if (fall) busy <= 1'b1;
            end
            if (tmr_done) begin
                busy <= 1'b0;
                hold <= 1'b0;
            end
        end
    end

    assign dout_en   = !cs_n;
    assign busy_en   = !cs_n || (state == ST_INT_CONV);
    assign low_power = (pd_q == PD_AUTO) && !acquire && !hold;

    AST_HUNT_IGNORES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HUNT) && rise && !din) |=> (state == ST_HUNT)) else $error("zero taken as start"); // R1
    AST_ABORT_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CMD) && cs_n) |=> (state == ST_HUNT)) else $error("abort missed"); // R10
    AST_EXT_BUSY_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && (pd_q != PD_INTCLK)) |-> !sh_empty) else $error("busy without sample"); // R3
    AST_INT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INT_CONV) |-> busy) else $error("busy dropped in conversion"); // R7

endmodule

// File: tb/tb_adc_serial_slave.sv
module tb_adc_serial_slave;
    localparam int DW   = 16;
    localparam int CONV = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          dclk = 1'b0;
    logic          din = 1'b0;
    logic [DW-1:0] sample = '0;
    logic          dout, dout_en, busy, busy_en, single_ended, acquire, hold, low_power;
    logic [2:0]    chan_sel;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    adc_serial_slave #(.DATA_W(DW), .CONV_CYCLES(CONV)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk), .din(din), .sample(sample),
        .dout(dout), .dout_en(dout_en), .busy(busy), .busy_en(busy_en),
        .chan_sel(chan_sel), .single_ended(single_ended), .acquire(acquire),
        .hold(hold), .low_power(low_power)
    );

    function automatic logic [7:0] mkcmd(input logic [2:0] ch, input logic sg, input logic [1:0] pd);
        return {1'b1, ch, 1'b0, sg, pd};
    endfunction

    function automatic logic exp_lp(input logic [1:0] pd);
        return (pd == 2'b00);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic dbit(input logic d, output logic o_d, output logic o_b, output logic o_a, output logic o_h);
        @(negedge clk);
        din  = d;
        dclk = 1'b1;
        repeat (2) @(negedge clk);
        o_a  = acquire;
        o_h  = hold;
        dclk = 1'b0;
        repeat (2) @(negedge clk);
        o_d  = dout;
        o_b  = busy;
    endtask

    task automatic ext_frame(input logic [2:0] ch, input logic sg, input logic [1:0] pd,
                             input logic [DW-1:0] data, input int tail);
        logic [7:0] c;
        logic o_d, o_b, o_a, o_h;
        c = mkcmd(ch, sg, pd);
        sample = data;
        for (int i = 7; i >= 0; i--) begin
            dbit(c[i], o_d, o_b, o_a, o_h);
            chk("R6 zero on dout while command arrives", o_d, 0);
            if (i == 0) begin
                chk("R2 acquire low at eighth edge", o_a, 0);
                chk("R2 hold at eighth edge", o_h, 1);
                chk("R3 busy after last command bit", o_b, 1);
            end else begin
                chk("R2 acquire phase", o_a, (i <= 2) ? 1 : 0);
                chk("R2 hold idle", o_h, 0);
                chk("R3 busy idle during command", o_b, 0);
            end
        end
        chk("R2 chan_sel", chan_sel, ch);
        chk("R2 single_ended", single_ended, sg);
        chk("R9 no low power while holding", low_power, 0);
        for (int k = DW - 1; k >= 0; k--) begin
            dbit(1'b0, o_d, o_b, o_a, o_h);
            chk("R4 result bit", o_d, data[k]);
            chk("R3 busy single period", o_b, 0);
        end
        chk("R4 hold released after LSB", hold, 0);
        chk("R9 low power flag", low_power, exp_lp(pd));
        for (int t = 0; t < tail; t++) begin
            dbit(1'b0, o_d, o_b, o_a, o_h);
            chk("R4 zero fill", o_d, 0);
        end
    endtask

    task automatic int_frame(input logic [2:0] ch, input logic sg, input logic [DW-1:0] data,
                             input logic cs_off);
        logic [7:0] c;
        logic o_d, o_b, o_a, o_h;
        c = mkcmd(ch, sg, 2'b10);
        sample = data;
        for (int i = 7; i >= 0; i--) begin
            dbit(c[i], o_d, o_b, o_a, o_h);
        end
        chk("R7 busy at conversion start", o_b, 1);
        chk("R7 hold at conversion start", hold, 1);
        if (cs_off) begin
            @(negedge clk);
            cs_n = 1'b1;
            repeat (2) @(negedge clk);
            chk("R8 busy_en kept in conversion", busy_en, 1);
            chk("R5 dout_en off", dout_en, 0);
        end
        repeat (CONV / 2) @(negedge clk);
        chk("R7 busy through conversion", busy, 1);
        repeat (CONV / 2 + 6) @(negedge clk);
        chk("R7 busy falls after conversion", busy, 0);
        chk("R7 hold falls after conversion", hold, 0);
        sample = ~data;
        if (cs_off) begin
            chk("R5 busy_en off after conversion", busy_en, 0);
            repeat (5) @(negedge clk);
            cs_n = 1'b0;
            repeat (2) @(negedge clk);
        end
        for (int k = DW - 1; k >= 0; k--) begin
            dbit(1'b0, o_d, o_b, o_a, o_h);
            chk("R8 internal result bit", o_d, data[k]);
        end
        for (int t = 0; t < 2; t++) begin
            dbit(1'b0, o_d, o_b, o_a, o_h);
            chk("R4 zero fill internal", o_d, 0);
        end
        chk("R9 low power off in internal mode", low_power, 0);
    endtask

    task automatic cs_pulse();
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic o_d, o_b, o_a, o_h;
        logic [1:0] pd;
        int r, tail;
        void'($urandom(32'h1BADCAFE));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 dout", dout, 0);
        chk("R11 busy", busy, 0);
        chk("R11 acquire", acquire, 0);
        chk("R11 hold", hold, 0);
        chk("R11 chan_sel", chan_sel, 0);
        chk("R11 single_ended", single_ended, 0);
        chk("R11 low_power", low_power, 1);
        chk("R5 dout_en at reset", dout_en, 0);
        chk("R5 busy_en at reset", busy_en, 0);

        // leading zeros ignored
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 dout_en selected", dout_en, 1);
        for (int i = 0; i < 5; i++) begin
            dbit(1'b0, o_d, o_b, o_a, o_h);
            chk("R1 zeros ignored acquire", o_a, 0);
            chk("R1 zeros ignored busy", o_b, 0);
        end
        ext_frame(3'b101, 1'b1, 2'b11, 16'h8001, 0);
        ext_frame(3'b010, 1'b0, 2'b00, 16'hFFFF, 8);

        // abort in mid command
        dbit(1'b1, o_d, o_b, o_a, o_h);
        dbit(1'b1, o_d, o_b, o_a, o_h);
        dbit(1'b1, o_d, o_b, o_a, o_h);
        dbit(1'b1, o_d, o_b, o_a, o_h);
        cs_pulse();
        chk("R10 chan_sel kept on abort", chan_sel, 3'b010);
        chk("R10 acquire idle on abort", acquire, 0);
        ext_frame(3'b011, 1'b1, 2'b01, 16'h0000, 2);
        chk("R9 reserved mode no low power", low_power, 0);

        // edges ignored while deselected
        @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) dbit(1'b1, o_d, o_b, o_a, o_h);
        chk("R5 no hold while deselected", hold, 0);
        chk("R5 no busy while deselected", busy, 0);
        chk("R5 chan_sel unchanged", chan_sel, 3'b011);
        chk("R5 dout_en off", dout_en, 0);
        chk("R5 busy_en off", busy_en, 0);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);

        // internal clock mode, selected and deselected
        int_frame(3'b110, 1'b0, 16'hA5C3, 1'b0);
        int_frame(3'b001, 1'b1, 16'h3C5A, 1'b1);

        // random back-to-back and padded frames
        for (int f = 0; f < 40; f++) begin
            r = int'($urandom % 4);
            if (r == 3) begin
                int_frame(3'($urandom), 1'($urandom), 16'($urandom), 1'($urandom));
            end else begin
                pd = (r == 0) ? 2'b00 : ((r == 1) ? 2'b01 : 2'b11);
                tail = ($urandom % 2 == 0) ? 0 : 8;
                ext_frame(3'($urandom), 1'($urandom), pd, 16'($urandom), tail);
                if (tail != 0) cs_pulse();
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule